// File: doc/BRIEF.md
# Self-Clocked Serial Result Port

This block is the serial output stage of a converter that acts as the bus master. It divides time into fixed frames of 32 internal clock cycles. Each frame opens with a one-cycle data-ready pulse. On the same clock edge that raises data-ready, the block copies the 16-bit result word into a shift register. During the 31 cycles that follow, it shifts the word out, most significant bit first, on a serial clock that it produces itself. Data moves on the rising edge of the serial clock, so a receiver samples it on the falling edge. The frame-sync output is a copy of data-ready, so a receiver can take its word framing from either pin.

The timing is run by a small state machine with three states. ST_HALT is the reset and standby state; all outputs are low. ST_LOAD is the single data-ready cycle, in which the word is captured. ST_SHIFT covers the 31 low cycles of the frame. The named transitions are:

- HALT_TO_LOAD: taken when standby is low.
- LOAD_TO_SHIFT: always taken after the data-ready cycle.
- SHIFT_TO_LOAD: taken at the end of the frame.
- ANY_TO_HALT: taken whenever standby is high.

The frame rate is the internal clock divided by 32. With a 15 MHz internal clock, the block delivers 468.75 thousand words per second.

Top module: `conv_serial_tx`

## Requirements
- R1: Cycles are numbered within a frame, with the data-ready cycle as cycle 0. `drdy` is high for exactly one clock cycle and low for the next 31, so successive rising edges of `drdy` are 32 cycles apart while `stby` stays low.
- R2: The word sent in a frame is the value present on `result` at the clock edge that raises `drdy`. Changing `result` at any other time has no effect on that frame.
- R3: Each frame sends the captured 16 bits most significant bit first: bit 15 is the first bit and bit 0 is the last.
- R4: Outside standby, `sdata` changes only at a rising edge of `sclk`. It holds its value across every falling edge of `sclk`, and the receiver samples each bit at that falling edge.
- R5: Within a frame, `sclk` is high in cycles 1, 3, ..., 31 and low in every other cycle, including cycle 0. This gives exactly 16 rising edges per frame.
- R6: `fsync` carries the same value as `drdy` in every cycle.
- R7: From the clock edge at which `stby` is sampled high, and for as long as it stays high, `drdy`, `fsync`, `sclk` and `sdata` are all low. Any frame in progress is abandoned.
- R8: At the first clock edge at which `stby` is sampled low after standby, a fresh frame starts. `drdy` rises at that edge and the current `result` is captured.
- R9: While `rst` is high, all outputs are low. The first frame starts at the first clock edge after `rst` falls, provided `stby` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock; one frame is 32 of its cycles |
| rst | input | 1 | Asynchronous reset, active high |
| stby | input | 1 | Standby request, active high |
| result | input | 16 | Result word, captured when `drdy` rises |
| drdy | output | 1 | Data-ready pulse, one cycle per frame |
| fsync | output | 1 | Frame sync, equal to `drdy` |
| sclk | output | 1 | Serial clock generated by the block, idles low |
| sdata | output | 1 | Serial data, launched on rising `sclk` |

## Verification
If the frame counter or the state register goes wrong, the next `drdy` pulse arrives at the wrong distance from the previous one, or the frame carries a wrong number of `sclk` pulses. Either fault is visible within one 32-cycle frame. If the shift register goes wrong, the word rebuilt from the falling `sclk` edges differs from the captured `result`, which shows up at the end of that same frame. A fault on the standby path shows either as activity on any output in the cycle after `stby` is sampled high, or as a missing `drdy` in the cycle after `stby` is sampled low.

// File: rtl/cst_pkg.sv
package cst_pkg;

    // Default geometry: bits per word and internal cycles per frame.
    localparam int unsigned CST_WORD_W    = 16;
    localparam int unsigned CST_FRAME_LEN = 32;

    // Frame sequencer states.
    typedef enum logic [1:0] {
        ST_HALT  = 2'd0,   // reset / standby, all outputs low
        ST_LOAD  = 2'd1,   // data-ready cycle, word captured
        ST_SHIFT = 2'd2    // remaining cycles of the frame
    } cst_state_t;

endpackage

// File: rtl/cst_frame_ctrl.sv
module cst_frame_ctrl
    import cst_pkg::*;
#(
    parameter int unsigned WORD_W    = CST_WORD_W,
    parameter int unsigned FRAME_LEN = CST_FRAME_LEN
) (
    input  logic clk,
    input  logic rst,
    input  logic stby,
    output logic drdy_o,
    output logic sclk_o,
    output logic load_o,
    output logic launch_o,
    output logic clear_o
);

    localparam int unsigned CNT_W = $clog2(FRAME_LEN);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(FRAME_LEN - 1);
    localparam logic [CNT_W-1:0] LAST_HI  = CNT_W'(2 * WORD_W - 1);

    cst_state_t       state, nxt;
    logic [CNT_W-1:0] cnt, nxt_cnt;
    logic             nxt_hi;

    // Next-state logic: standby overrides every transition (ANY_TO_HALT).
    always_comb begin
        nxt = state;
        if (stby) begin
            nxt = ST_HALT;
        end else begin
            unique case (state)
                ST_HALT:  nxt = ST_LOAD;                          // HALT_TO_LOAD
                ST_LOAD:  nxt = ST_SHIFT;                         // LOAD_TO_SHIFT
                ST_SHIFT: nxt = (cnt == LAST_CNT) ? ST_LOAD       // SHIFT_TO_LOAD
                                                  : ST_SHIFT;
                default:  nxt = ST_HALT;
            endcase
        end
    end

    // Cycle index inside the frame: 0 in the data-ready cycle, then 1, 2, ...
    always_comb begin
        nxt_cnt = (nxt == ST_SHIFT) ? cnt + CNT_W'(1) : '0;
        nxt_hi  = (nxt == ST_SHIFT) && nxt_cnt[0] && (nxt_cnt <= LAST_HI);
    end

    // State register.
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            state <= ST_HALT;
            cnt   <= '0;
        end else begin
            state <= nxt;
            cnt   <= nxt_cnt;
        end
    end

    // Output register: driven from the next state so the pins are registered.
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            drdy_o <= 1'b0;
            sclk_o <= 1'b0;
        end else begin
            drdy_o <= (nxt == ST_LOAD);
            sclk_o <= nxt_hi;
        end
    end

    // Strobes for the shifter, aligned with the edge at which the pins change.
    assign load_o   = (nxt == ST_LOAD);
    assign launch_o = nxt_hi;
    assign clear_o  = (nxt == ST_HALT);

endmodule

// File: rtl/cst_shifter.sv
module cst_shifter
    import cst_pkg::*;
#(
    parameter int unsigned WORD_W = CST_WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              launch,
    input  logic              clear,
    input  logic [WORD_W-1:0] din,
    output logic              sdata_o
);

    logic [WORD_W-1:0] shreg;

    // The serial output moves only on launch, i.e. with a rising serial clock.
    // A new word is loaded into shreg without disturbing the bit on sdata_o.
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            shreg   <= '0;
            sdata_o <= 1'b0;
        end else if (clear) begin
            shreg   <= '0;
            sdata_o <= 1'b0;
        end else if (load) begin
            shreg   <= din;
        end else if (launch) begin
            sdata_o <= shreg[WORD_W-1];
            shreg   <= {shreg[WORD_W-2:0], 1'b0};
        end
    end

endmodule

// File: rtl/conv_serial_tx.sv
module conv_serial_tx
    import cst_pkg::*;
#(
    parameter int unsigned WORD_W    = CST_WORD_W,
    parameter int unsigned FRAME_LEN = CST_FRAME_LEN
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stby,
    input  logic [WORD_W-1:0] result,
    output logic              drdy,
    output logic              fsync,
    output logic              sclk,
    output logic              sdata
);

    logic load_s, launch_s, clear_s;

    cst_frame_ctrl #(
        .WORD_W   (WORD_W),
        .FRAME_LEN(FRAME_LEN)
    ) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .stby    (stby),
        .drdy_o  (drdy),
        .sclk_o  (sclk),
        .load_o  (load_s),
        .launch_o(launch_s),
        .clear_o (clear_s)
    );

    cst_shifter #(
        .WORD_W(WORD_W)
    ) u_shift (
        .clk    (clk),
        .rst    (rst),
        .load   (load_s),
        .launch (launch_s),
        .clear  (clear_s),
        .din    (result),
        .sdata_o(sdata)
    );

    // Frame sync is the data-ready pulse itself.
    assign fsync = drdy;

endmodule

// File: rtl/conv_serial_tx_chk.sv
module conv_serial_tx_chk #(
    parameter int unsigned WORD_W    = 16,
    parameter int unsigned FRAME_LEN = 32
) (
    input logic clk,
    input logic rst,
    input logic stby,
    input logic drdy,
    input logic fsync,
    input logic sclk,
    input logic sdata
);

    localparam int unsigned GW = $clog2(FRAME_LEN) + 2;

    logic [GW-1:0] gap;
    logic [GW-1:0] rises;
    logic          seen;
    logic          sclk_d;

    // Observation counters: cycles since the last data-ready pulse,
    // and rising serial-clock edges seen within the current frame.
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            gap    <= '0;
            rises  <= '0;
            seen   <= 1'b0;
            sclk_d <= 1'b0;
        end else if (stby) begin
            gap    <= '0;
            rises  <= '0;
            seen   <= 1'b0;
            sclk_d <= 1'b0;
        end else begin
            sclk_d <= sclk;
            if (drdy) begin
                seen  <= 1'b1;
                gap   <= '0;
                rises <= '0;
            end else begin
                gap <= gap + GW'(1);
                if (sclk && !sclk_d) begin
                    rises <= rises + GW'(1);
                end
            end
        end
    end

    // R1
    drdy_single_chk: assert property (@(posedge clk) disable iff (rst)
        drdy |=> !drdy);

    // R1
    frame_len_chk: assert property (@(posedge clk) disable iff (rst)
        (drdy && seen) |-> (gap == GW'(FRAME_LEN - 1)));

    // R5
    sclk_count_chk: assert property (@(posedge clk) disable iff (rst)
        (drdy && seen) |-> (rises == GW'(WORD_W)));

    // R5
    sclk_idle_chk: assert property (@(posedge clk) disable iff (rst)
        drdy |-> !sclk);

    // R4
    sdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(sclk) && !$past(stby)) |-> $stable(sdata));

    // R7
    standby_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        stby |=> (!drdy && !fsync && !sclk && !sdata));

    // R8
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        (!stby && $past(stby)) |=> drdy);

endmodule

bind conv_serial_tx conv_serial_tx_chk #(
    .WORD_W   (WORD_W),
    .FRAME_LEN(FRAME_LEN)
) u_chk (
    .clk  (clk),
    .rst  (rst),
    .stby (stby),
    .drdy (drdy),
    .fsync(fsync),
    .sclk (sclk),
    .sdata(sdata)
);

// File: tb/conv_serial_tx_tb.sv
module conv_serial_tx_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        stby;
    logic [15:0] result;
    logic        drdy, fsync, sclk, sdata;

    int tests  = 0;
    int errors = 0;
    int words  = 0;
    bit done   = 1'b0;

    logic [15:0] exp_q[$];

    always #2.5 clk = ~clk;   // 200 MHz

    conv_serial_tx u_dut (
        .clk   (clk),
        .rst   (rst),
        .stby  (stby),
        .result(result),
        .drdy  (drdy),
        .fsync (fsync),
        .sclk  (sclk),
        .sdata (sdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_drdy();
        do @(negedge clk); while (drdy !== 1'b1);
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, errors);
    endtask

    // Monitor: rebuilds words from falling sclk edges and checks the framing.
    logic        prev_sclk  = 1'b0;
    logic        prev_sdata = 1'b0;
    logic [15:0] acc        = '0;
    int          bitcnt     = 0;
    int          gap        = 0;
    int          rises      = 0;
    bit          have_prev  = 1'b0;

    always begin
        @(negedge clk);
        #1;
        if (rst === 1'b1 || stby === 1'b1) begin
            acc = '0; bitcnt = 0; gap = 0; rises = 0; have_prev = 1'b0;
        end else begin
            if (fsync !== drdy) begin
                errors++;
                $display("FAIL R6 fsync actual=%b expected=%b", fsync, drdy);
            end
            if (sdata !== prev_sdata && !(sclk && !prev_sclk)) begin
                errors++;
                $display("FAIL R4 sdata moved without rising sclk actual=%b expected=%b",
                         sdata, prev_sdata);
            end
            if (sclk && !prev_sclk) rises++;
            if (!sclk && prev_sclk) begin
                acc = {acc[14:0], sdata};
                bitcnt++;
                if (bitcnt == 16) begin
                    bitcnt = 0;
                    words++;
                    if (exp_q.size() == 0) begin
                        tests++; errors++;
                        $display("FAIL R2 unexpected word actual=%h expected=none", acc);
                    end else begin
                        chk("R2 R3 word MSB first", {16'h0, acc}, {16'h0, exp_q.pop_front()});
                    end
                end
            end
            if (drdy) begin
                chk("R5 sclk low in data-ready cycle", {31'h0, sclk}, 32'h0);
                if (have_prev) begin
                    chk("R1 frame length", gap, 32);
                    chk("R5 sclk pulses per frame", rises, 16);
                end
                have_prev = 1'b1;
                gap = 1;
                rises = 0;
            end else begin
                gap++;
            end
        end
        prev_sclk  = sclk;
        prev_sdata = sdata;
    end

    // Driver: pushes each word it presents, one frame ahead of its capture.
    logic [15:0] pats [10] = '{16'hFFFF, 16'h0000, 16'h8001, 16'hA5A5, 16'h5A5A,
                               16'h7FFE, 16'h0001, 16'h8000, 16'hC3C3, 16'h1357};

    initial begin
        rst    = 1'b1;
        stby   = 1'b0;
        result = 16'hBEEF;
        exp_q.push_back(16'hBEEF);
        repeat (3) @(negedge clk);
        chk("R9 outputs low in reset", {28'h0, drdy, fsync, sclk, sdata}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        chk("R9 first drdy after reset", {31'h0, drdy}, 32'h1);
        result = pats[0];
        exp_q.push_back(pats[0]);
        for (int i = 1; i < 6; i++) begin
            wait_drdy();
            result = pats[i];
            exp_q.push_back(pats[i]);
        end

        // Standby in the middle of a frame: the word being sent is dropped.
        wait_drdy();
        repeat (9) @(negedge clk);
        stby   = 1'b1;
        result = 16'h1234;
        exp_q.delete();
        exp_q.push_back(16'h1234);
        repeat (6) begin
            @(negedge clk);
            chk("R7 outputs low in standby", {28'h0, drdy, fsync, sclk, sdata}, 32'h0);
        end
        stby = 1'b0;
        @(negedge clk);
        chk("R8 drdy on standby release", {31'h0, drdy}, 32'h1);
        result = pats[6];
        exp_q.push_back(pats[6]);
        for (int i = 7; i < 10; i++) begin
            wait_drdy();
            result = pats[i];
            exp_q.push_back(pats[i]);
        end
        wait_drdy();
        repeat (34) @(negedge clk);
        chk("R3 words received", words, 11);
        chk("R2 queue drained", exp_q.size(), 0);
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

endmodule